// File: doc/BRIEF.md
# Colour Lookup Palette Store

This block holds a 256-entry colour table used by a display pipeline to turn 8-bit pixel indices into 24-bit colours. Storage is organised as 128 words of 32 bits, and each word packs two 16-bit palette entries. Software writes and reads whole words through a simple word-addressed bus port. A read returns each word exactly as it was written, including the two intensity bits.

A separate lookup port accepts an 8-bit index with a valid strobe. One clock later it presents the selected entry with each 5-bit channel widened to 8 bits, together with a matching valid. The intensity bit of an entry is kept in storage but plays no part in the colour that comes out of a lookup.

Top module: `clut_palette`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, every word reads back as 0 on `bus_rdata` and `px_valid` is 0.
- R2: On a rising edge with `bus_we` high, the full 32-bit `bus_wdata` is stored at word `bus_addr`. `bus_rdata` shows the stored word at `bus_addr` combinationally, bit for bit, including bits 15 and 31.
- R3: A lookup of index `lk_index` reads word `lk_index[7:1]`. Bit `lk_index[0]`=0 selects bits 15:0 of that word and `lk_index[0]`=1 selects bits 31:16.
- R4: Within the selected 16-bit entry, bits 14:10 drive `px_color[23:16]`, bits 9:5 drive `px_color[15:8]`, and bits 4:0 drive `px_color[7:0]`.
- R5: Each 5-bit field becomes the upper five bits of its 8-bit output lane. The three low bits of every lane are 0.
- R6: Bit 15 of an entry has no effect on the looked-up colour, although it is still stored and read back.
- R7: `px_valid` equals `lk_valid` from the previous clock edge. When it is high, `px_color` is the colour of the index presented at that edge.
- R8: If a lookup and a bus write to the same word share a clock edge, the lookup returns the contents held before the write.
- R9: At an edge where `lk_valid` is low, `px_color` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Word write strobe |
| bus_addr | input | 7 | Word address for read and write |
| bus_wdata | input | 32 | Word to store |
| bus_rdata | output | 32 | Stored word at bus_addr |
| lk_valid | input | 1 | Lookup request strobe |
| lk_index | input | 8 | Palette entry index |
| px_valid | output | 1 | Lookup result valid |
| px_color | output | 24 | Expanded colour {ch_hi, green, ch_lo} |

## Verification
Four properties are checked on every cycle:
- the one-cycle valid pipeline,
- the zero low bits in each colour lane,
- colour hold when no lookup is made,
- exact readback of a word in the cycle after it is written.

The bench's scenarios are needed for the following:
- which half-word a lookup selects and how the fields land in the output;
- that the intensity bit is ignored;
- the old-data result when a write and a lookup collide;
- the zeroed contents after reset.

// File: rtl/clut_pkg.sv
// Shared widths and the channel expansion rule for the palette store.
// Assumes 5:5:5 entries with one spare intensity bit in a 16-bit half-word.
package clut_pkg;
    localparam int WORD_W   = 32;
    localparam int ENTRY_W  = 16;
    localparam int CH_W     = 5;
    localparam int LANE_W   = 8;
    localparam int PAD_W    = LANE_W - CH_W;
    localparam int COLOR_W  = 3 * LANE_W;

    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [COLOR_W-1:0] color_t;

    // Widen one entry into three 8-bit lanes; bit 15 is dropped.
    function automatic color_t expand_entry(input entry_t e);
        return {e[3*CH_W-1:2*CH_W], {PAD_W{1'b0}},
                e[2*CH_W-1:CH_W],   {PAD_W{1'b0}},
                e[CH_W-1:0],        {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/clut_word_bank.sv
// Register bank of palette words with one write port and two
// combinational read ports. Assumes a synchronous active-low reset clears
// every word, and that writes land on the rising edge.
module clut_word_bank #(
    parameter int AW = 7,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Hold one word; clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (we && (waddr == AW'(g)))
                words[g] <= wdata;
        end
    end

    // Combinational read ports; a same-edge write is seen only afterwards.
    always_comb begin
        rdata_a = words[raddr_a];
        rdata_b = words[raddr_b];
    end
endmodule

// File: rtl/clut_half_pick.sv
// Picks the even or odd entry of a palette word and widens it to a colour.
// Assumes the even entry lives in the low half of the word.
module clut_half_pick
    import clut_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              odd,
    output color_t            color
);
    entry_t sel;

    // Choose the half, then apply the shared expansion rule.
    always_comb begin
        sel   = odd ? word[WORD_W-1:ENTRY_W] : word[ENTRY_W-1:0];
        color = expand_entry(sel);
    end
endmodule

// File: rtl/clut_palette.sv
// Palette store top: word bus port plus a one-cycle lookup port.
// Assumes the caller keeps bus_addr stable while reading bus_rdata.
module clut_palette
    import clut_pkg::*;
#(
    parameter int WORD_AW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [WORD_AW-1:0]   bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic                 lk_valid,
    input  logic [WORD_AW:0]     lk_index,
    output logic                 px_valid,
    output logic [COLOR_W-1:0]   px_color
);
    logic [WORD_W-1:0] lk_word;
    color_t            lk_color;

    clut_word_bank #(.AW(WORD_AW), .DW(WORD_W)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .waddr   (bus_addr),
        .wdata   (bus_wdata),
        .raddr_a (bus_addr),
        .rdata_a (bus_rdata),
        .raddr_b (lk_index[WORD_AW:1]),
        .rdata_b (lk_word)
    );

    clut_half_pick i_pick (
        .word  (lk_word),
        .odd   (lk_index[0]),
        .color (lk_color)
    );

    // Output stage: register the colour and its valid for a fixed one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_valid <= 1'b0;
            px_color <= '0;
        end else begin
            px_valid <= lk_valid;
            if (lk_valid)
                px_color <= lk_color;
        end
    end
endmodule

// File: rtl/clut_palette_chk.sv
// Cycle-level properties of the palette store, bound onto every instance.
module clut_palette_chk #(
    parameter int WORD_AW = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [WORD_AW-1:0] bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic               lk_valid,
    input logic               px_valid,
    input logic [23:0]        px_color
);
    // R7: valid follows the request by exactly one edge.
    a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (px_valid == $past(lk_valid)));

    // R5: the three low bits of each lane are always zero.
    a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (px_color[2:0] == 3'b0 && px_color[10:8] == 3'b0
                      && px_color[18:16] == 3'b0));

    // R9: no request means the colour holds.
    a_r9_color_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lk_valid)) |-> $stable(px_color));

    // R2: a written word reads back unchanged on the next cycle.
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we) && !bus_we && bus_addr == $past(bus_addr))
        |-> (bus_rdata == $past(bus_wdata)));
endmodule

bind clut_palette clut_palette_chk #(.WORD_AW(WORD_AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lk_valid  (lk_valid),
    .px_valid  (px_valid),
    .px_color  (px_color)
);

// File: tb/test_clut_palette.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module test_clut_palette;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lk_valid = 1'b0;
    logic [7:0]  lk_index = '0;
    logic        px_valid;
    logic [23:0] px_color;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    clut_palette i_clut_palette (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_valid(lk_valid),
        .lk_index(lk_index), .px_valid(px_valid), .px_color(px_color)
    );

    // {word address, word}
    localparam logic [38:0] VEC [6] = '{
        {7'd0,   32'h7FFF_0000},
        {7'd1,   32'h001F_7C00},
        {7'd2,   32'h03E0_8421},
        {7'd63,  32'hFFFF_FFFF},
        {7'd100, 32'h1234_5678},
        {7'd127, 32'h8001_7FFE}
    };

    function automatic logic [23:0] exp_color(input logic [15:0] e);
        return {e[14:10], 3'b000, e[9:5], 3'b000, e[4:0], 3'b000};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic read_word(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic lookup(input logic [7:0] idx, output logic [23:0] c, output logic v);
        @(negedge clk);
        lk_valid = 1'b1; lk_index = idx;
        @(posedge clk); #1;
        c = px_color; v = px_valid;
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [23:0] col;
        logic        v;

        repeat (3) @(posedge clk);
        #1;
        check("R1 px_valid after reset", {31'b0, px_valid}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        read_word(7'd0, rd);   check("R1 word 0 zero", rd, 32'h0);
        read_word(7'd127, rd); check("R1 word 127 zero", rd, 32'h0);
        lookup(8'd77, col, v);
        check("R1 lookup of cleared entry", {8'b0, col}, 32'h0);

        for (int i = 0; i < 6; i++) write_word(VEC[i][38:32], VEC[i][31:0]);

        // Walk the table: readback, even entry, odd entry.
        for (int i = 0; i < 6; i++) begin
            logic [6:0]  a;
            logic [31:0] w;
            a = VEC[i][38:32];
            w = VEC[i][31:0];
            read_word(a, rd);
            check("R2 readback", rd, w);
            lookup({a, 1'b0}, col, v);
            check("R3 R4 R5 even entry", {8'b0, col}, {8'b0, exp_color(w[15:0])});
            check("R7 valid", {31'b0, v}, 32'h1);
            lookup({a, 1'b1}, col, v);
            check("R3 R4 R5 odd entry", {8'b0, col}, {8'b0, exp_color(w[31:16])});
        end

        // R6: intensity bit set versus clear gives the same colour.
        write_word(7'd10, 32'h8123_0123);
        read_word(7'd10, rd);
        check("R6 intensity stored", rd, 32'h8123_0123);
        lookup(8'd21, col, v);
        check("R6 odd with intensity", {8'b0, col}, {8'b0, exp_color(16'h0123)});
        lookup(8'd20, col, v);
        check("R6 even without intensity", {8'b0, col}, {8'b0, exp_color(16'h0123)});

        // R8: write and lookup of word 10 on the same edge.
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 7'd10; bus_wdata = 32'h0000_7FFF;
        lk_valid = 1'b1; lk_index = 8'd20;
        @(posedge clk); #1;
        bus_we = 1'b0; lk_valid = 1'b0;
        check("R8 old data on collision", {8'b0, px_color}, {8'b0, exp_color(16'h0123)});
        lookup(8'd20, col, v);
        check("R8 new data next lookup", {8'b0, col}, {8'b0, exp_color(16'h7FFF)});

        // R9 and R7: idle cycle holds the colour and drops valid.
        @(negedge clk);
        lk_index = 8'd0;
        @(posedge clk); #1;
        check("R9 colour held", {8'b0, px_color}, {8'b0, exp_color(16'h7FFF)});
        check("R7 valid low when idle", {31'b0, px_valid}, 32'h0);

        // R1: a second reset clears written words.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); rst_n = 1'b1;
        read_word(7'd63, rd);
        check("R1 written word cleared", rd, 32'h0);
        check("R1 px_valid after reset", {31'b0, px_valid}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule